// File: doc/BRIEF.md
# Parallel Slave Bus Port

This block lets an external 8-bit microprocessor exchange bytes with the local processor through a pair of data latches. The external side has no clock. It drives three active-low controls: chip select, write strobe and read strobe. It writes a byte into an inbound latch and reads a byte from an outbound latch. The controls are synchronised into the local clock domain. A transfer is recognised once chip select and a strobe are seen low together. It is acted on when that combined condition ends.

The local side has a simple register interface. A one-cycle read pulse consumes the inbound byte. A one-cycle write pulse loads the outbound byte. Two further pulses clear the sticky flags. Four status outputs report the port state: inbound-full, outbound-full, overflow and an interrupt request. The interrupt request rises whenever an external transfer completes. A mode enable input gates the whole external side. While it is low, the control pins have no effect and the data bus is never driven.

Top module: `pbus_slave_port`

## Requirements
- R1: After reset, `ibf`, `obf`, `ovf`, `irq` and `ext_data_oe` are 0, and `loc_in_data` is 0.
- R2: An external write (`ext_cs_n` and `ext_wr_n` both low, with `mode_en` high) is acted on when the write strobe rises. On the third rising clock edge after that release, `loc_in_data` takes the value of `ext_data_in`, and `ibf` and `irq` become 1. After the second edge they have not yet changed.
- R3: A write strobe pulse while `ext_cs_n` stays high has no effect: `ibf`, `irq` and `loc_in_data` are unchanged.
- R4: `ext_data_oe` is 1, and `ext_data_out` carries the outbound latch, only while `mode_en` is 1 and `ext_cs_n` and `ext_rd_n` are both 0. In every other case `ext_data_oe` is 0.
- R5: A one-cycle `loc_out_wr` pulse loads `loc_out_wdata` into the outbound latch and sets `obf` at the next clock edge.
- R6: An external read completes when the combined chip-select/read-strobe condition ends. On the third rising edge after the strobe rises, `obf` clears and `irq` becomes 1. After the second edge `obf` is still 1.
- R7: A one-cycle `loc_in_rd` pulse clears `ibf` at the next edge. `loc_in_data` keeps its value.
- R8: An external write that completes while `ibf` is 1 sets `ovf` and still captures the new byte. `ovf` stays 1 through local reads until a `loc_ovf_clr` pulse clears it.
- R9: `irq` stays 1 until a `loc_irq_clr` pulse clears it. If a clear and a transfer completion fall in the same cycle, `irq` stays 1.
- R10: While `mode_en` is 0, external writes and reads change no flag and no latch, and `ext_data_oe` stays 0.
- R11: An external write whose chip select rises before its write strobe is also captured, three edges after the chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Enables the external port |
| ext_cs_n | input | 1 | External chip select, active low, asynchronous |
| ext_wr_n | input | 1 | External write strobe, active low, asynchronous |
| ext_rd_n | input | 1 | External read strobe, active low, asynchronous |
| ext_data_in | input | 8 | Byte driven by the external master |
| ext_data_out | output | 8 | Outbound byte presented to the external master |
| ext_data_oe | output | 1 | Drive enable for the external data bus |
| loc_in_rd | input | 1 | Local pulse: consume the inbound byte |
| loc_in_data | output | 8 | Inbound latch contents |
| loc_out_wr | input | 1 | Local pulse: load the outbound latch |
| loc_out_wdata | input | 8 | Byte for the outbound latch |
| loc_irq_clr | input | 1 | Local pulse: clear the interrupt request |
| loc_ovf_clr | input | 1 | Local pulse: clear the overflow flag |
| ibf | output | 1 | Inbound latch holds an unread byte |
| obf | output | 1 | Outbound latch not yet read externally |
| ovf | output | 1 | Sticky inbound overflow |
| irq | output | 1 | Sticky interrupt request |

## Verification
External results follow three clock edges after the strobe or chip select rises. Two edges go to the synchroniser and one to the flag register. The bench drives inputs on falling edges and counts rising edges exactly. For the first write and for the read, it checks that nothing has changed after two edges and that the result is present after the third. Local pulses take effect one edge later and are checked at the falling edge that follows. The output enable is combinational from the pins and is sampled one time step after the pins change. For the interrupt race, the clear pulse is placed in the single cycle in which the completion event is pending.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int PBUS_DATA_W   = 8;
    localparam int PBUS_CTRL_W   = 3;
    localparam int PBUS_CTRL_CS  = 2;
    localparam int PBUS_CTRL_WR  = 1;
    localparam int PBUS_CTRL_RD  = 0;

    // Combined external conditions seen in the previous cycle
    typedef struct packed {
        logic wr_act;
        logic rd_act;
    } pbus_xfer_t;

    // Local status flags
    typedef struct packed {
        logic ibf;
        logic obf;
        logic ovf;
        logic irq;
    } pbus_flag_t;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int              W      = 3,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    IDLE   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stage_d[g] = async_i;
            end else begin : g_next
                assign stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= IDLE;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/pbus_xfer_detect.sv
module pbus_xfer_detect
    import pbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic cs_s_n,
    input  logic wr_s_n,
    input  logic rd_s_n,
    output logic wr_evt,
    output logic rd_evt
);

    pbus_xfer_t st_d, st_q;
    logic       wr_now;
    logic       rd_now;

    always_comb begin
        // Combined condition, qualified by chip select
        wr_now = ~cs_s_n & ~wr_s_n;
        rd_now = ~cs_s_n & ~rd_s_n;

        // An event fires when a condition seen last cycle has ended
        wr_evt = mode_en & st_q.wr_act & ~wr_now;
        rd_evt = mode_en & st_q.rd_act & ~rd_now;

        st_d        = st_q;
        st_d.wr_act = mode_en & wr_now;
        st_d.rd_act = mode_en & rd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pbus_flag_regs.sv
module pbus_flag_regs
    import pbus_pkg::*;
#(
    parameter int DATA_W = PBUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  logic [DATA_W-1:0] ext_data_in,
    input  logic              loc_in_rd,
    input  logic              loc_out_wr,
    input  logic [DATA_W-1:0] loc_out_wdata,
    input  logic              loc_irq_clr,
    input  logic              loc_ovf_clr,
    output logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output pbus_flag_t        flags
);

    typedef struct packed {
        logic [DATA_W-1:0] in_byte;
        logic [DATA_W-1:0] out_byte;
        pbus_flag_t        fl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;

        if (wr_evt) begin
            r_d.in_byte = ext_data_in;
        end
        if (loc_out_wr) begin
            r_d.out_byte = loc_out_wdata;
        end

        // For every flag, a set in the same cycle as a clear wins
        r_d.fl.ibf = wr_evt | (r_q.fl.ibf & ~loc_in_rd);
        r_d.fl.obf = loc_out_wr | (r_q.fl.obf & ~rd_evt);
        r_d.fl.ovf = (wr_evt & r_q.fl.ibf & ~loc_in_rd)
                   | (r_q.fl.ovf & ~loc_ovf_clr);
        r_d.fl.irq = wr_evt | rd_evt | (r_q.fl.irq & ~loc_irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_data  = r_q.in_byte;
    assign out_data = r_q.out_byte;
    assign flags    = r_q.fl;

endmodule

// File: rtl/pbus_slave_port.sv
module pbus_slave_port
    import pbus_pkg::*;
#(
    parameter int DATA_W      = PBUS_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              ext_cs_n,
    input  logic              ext_wr_n,
    input  logic              ext_rd_n,
    input  logic [DATA_W-1:0] ext_data_in,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              ext_data_oe,
    input  logic              loc_in_rd,
    output logic [DATA_W-1:0] loc_in_data,
    input  logic              loc_out_wr,
    input  logic [DATA_W-1:0] loc_out_wdata,
    input  logic              loc_irq_clr,
    input  logic              loc_ovf_clr,
    output logic              ibf,
    output logic              obf,
    output logic              ovf,
    output logic              irq
);

    logic [PBUS_CTRL_W-1:0] ctrl_raw;
    logic [PBUS_CTRL_W-1:0] ctrl_s;
    logic                   wr_evt;
    logic                   rd_evt;
    logic [DATA_W-1:0]      out_data;
    pbus_flag_t             flags;

    always_comb begin
        ctrl_raw               = '1;
        ctrl_raw[PBUS_CTRL_CS] = ext_cs_n;
        ctrl_raw[PBUS_CTRL_WR] = ext_wr_n;
        ctrl_raw[PBUS_CTRL_RD] = ext_rd_n;
    end

    pbus_sync #(
        .W      (PBUS_CTRL_W),
        .STAGES (SYNC_STAGES),
        .IDLE   ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctrl_raw),
        .sync_o  (ctrl_s)
    );

    pbus_xfer_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_en (mode_en),
        .cs_s_n  (ctrl_s[PBUS_CTRL_CS]),
        .wr_s_n  (ctrl_s[PBUS_CTRL_WR]),
        .rd_s_n  (ctrl_s[PBUS_CTRL_RD]),
        .wr_evt  (wr_evt),
        .rd_evt  (rd_evt)
    );

    pbus_flag_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_evt        (wr_evt),
        .rd_evt        (rd_evt),
        .ext_data_in   (ext_data_in),
        .loc_in_rd     (loc_in_rd),
        .loc_out_wr    (loc_out_wr),
        .loc_out_wdata (loc_out_wdata),
        .loc_irq_clr   (loc_irq_clr),
        .loc_ovf_clr   (loc_ovf_clr),
        .in_data       (loc_in_data),
        .out_data      (out_data),
        .flags         (flags)
    );

    // The bus drive follows the raw pins so that the master sees data within its own access
    always_comb begin
        ext_data_oe  = mode_en & ~ext_cs_n & ~ext_rd_n;
        ext_data_out = ext_data_oe ? out_data : '0;
    end

    assign ibf = flags.ibf;
    assign obf = flags.obf;
    assign ovf = flags.ovf;
    assign irq = flags.irq;

endmodule

// File: rtl/pbus_slave_port_chk.sv
module pbus_slave_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_en,
    input logic              ext_cs_n,
    input logic              ext_data_oe,
    input logic [DATA_W-1:0] ext_data_in,
    input logic [DATA_W-1:0] loc_in_data,
    input logic              loc_in_rd,
    input logic              loc_out_wr,
    input logic              loc_irq_clr,
    input logic              loc_ovf_clr,
    input logic              wr_evt,
    input logic              rd_evt,
    input logic              ibf,
    input logic              obf,
    input logic              ovf,
    input logic              irq
);

    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> (ibf && loc_in_data == $past(ext_data_in))); // R2

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_n |-> !ext_data_oe); // R4

    AST_OBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        loc_out_wr |=> obf); // R5

    AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !loc_out_wr) |=> !obf); // R6

    AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_in_rd && !wr_evt) |=> !ibf); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !loc_ovf_clr) |=> ovf); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !loc_irq_clr) |=> irq); // R9

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_irq_clr && (wr_evt || rd_evt)) |=> irq); // R9

    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (!ext_data_oe && !wr_evt && !rd_evt)); // R10

endmodule

bind pbus_slave_port pbus_slave_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_en     (mode_en),
    .ext_cs_n    (ext_cs_n),
    .ext_data_oe (ext_data_oe),
    .ext_data_in (ext_data_in),
    .loc_in_data (loc_in_data),
    .loc_in_rd   (loc_in_rd),
    .loc_out_wr  (loc_out_wr),
    .loc_irq_clr (loc_irq_clr),
    .loc_ovf_clr (loc_ovf_clr),
    .wr_evt      (wr_evt),
    .rd_evt      (rd_evt),
    .ibf         (ibf),
    .obf         (obf),
    .ovf         (ovf),
    .irq         (irq)
);

// File: tb/pbus_slave_port_bench.sv
module pbus_slave_port_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b1;
    logic       ext_cs_n = 1'b1;
    logic       ext_wr_n = 1'b1;
    logic       ext_rd_n = 1'b1;
    logic [7:0] ext_data_in = 8'h00;
    logic [7:0] ext_data_out;
    logic       ext_data_oe;
    logic       loc_in_rd = 1'b0;
    logic [7:0] loc_in_data;
    logic       loc_out_wr = 1'b0;
    logic [7:0] loc_out_wdata = 8'h00;
    logic       loc_irq_clr = 1'b0;
    logic       loc_ovf_clr = 1'b0;
    logic       ibf, obf, ovf, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_slave_port u_pbus_slave_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_en       (mode_en),
        .ext_cs_n      (ext_cs_n),
        .ext_wr_n      (ext_wr_n),
        .ext_rd_n      (ext_rd_n),
        .ext_data_in   (ext_data_in),
        .ext_data_out  (ext_data_out),
        .ext_data_oe   (ext_data_oe),
        .loc_in_rd     (loc_in_rd),
        .loc_in_data   (loc_in_data),
        .loc_out_wr    (loc_out_wr),
        .loc_out_wdata (loc_out_wdata),
        .loc_irq_clr   (loc_irq_clr),
        .loc_ovf_clr   (loc_ovf_clr),
        .ibf           (ibf),
        .obf           (obf),
        .ovf           (ovf),
        .irq           (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // External write; release by write strobe or by chip select; returns with result due
    task automatic ext_write(input logic [7:0] val, input bit end_by_cs, input bit chk_lat,
                             input logic exp_before);
        @(negedge clk);
        ext_data_in = val;
        ext_cs_n    = 1'b0;
        ext_wr_n    = 1'b0;
        repeat (4) @(negedge clk);
        if (end_by_cs) ext_cs_n = 1'b1;
        else           ext_wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (chk_lat) check("R2 ibf not yet set after two edges", ibf, exp_before);
        @(posedge clk);
        @(negedge clk);
        ext_cs_n    = 1'b1;
        ext_wr_n    = 1'b1;
        ext_data_in = ~val;
    endtask

    task automatic ext_read(input bit exp_oe, input logic [7:0] exp_byte, input bit chk_lat);
        @(negedge clk);
        ext_cs_n = 1'b0;
        ext_rd_n = 1'b0;
        #1;
        check("R4/R10 oe during read", ext_data_oe, exp_oe);
        if (exp_oe) check("R4 data during read", ext_data_out, exp_byte);
        repeat (4) @(negedge clk);
        ext_rd_n = 1'b1;
        #1;
        check("R4 oe drops with read strobe", ext_data_oe, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (chk_lat) check("R6 obf still set after two edges", obf, 1);
        @(posedge clk);
        @(negedge clk);
        ext_cs_n = 1'b1;
    endtask

    task automatic loc_pulse_in_rd();
        @(negedge clk); loc_in_rd = 1'b1;
        @(negedge clk); loc_in_rd = 1'b0;
    endtask

    task automatic loc_pulse_irq_clr();
        @(negedge clk); loc_irq_clr = 1'b1;
        @(negedge clk); loc_irq_clr = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 ibf reset", ibf, 0);
        check("R1 obf reset", obf, 0);
        check("R1 ovf reset", ovf, 0);
        check("R1 irq reset", irq, 0);
        check("R1 oe reset", ext_data_oe, 0);
        check("R1 in_data reset", loc_in_data, 8'h00);
    endtask

    task automatic test_write();
        ext_write(8'hA5, 1'b0, 1'b1, 1'b0);
        check("R2 ibf set", ibf, 1);
        check("R2 irq set", irq, 1);
        check("R2 byte captured", loc_in_data, 8'hA5);
        check("R2 no overflow", ovf, 0);
    endtask

    task automatic test_local_read();
        loc_pulse_in_rd();
        check("R7 ibf cleared", ibf, 0);
        check("R7 byte held", loc_in_data, 8'hA5);
        loc_pulse_irq_clr();
        check("R9 irq cleared", irq, 0);
    endtask

    task automatic test_cs_gate();
        @(negedge clk);
        ext_data_in = 8'h3C;
        ext_wr_n    = 1'b0;
        repeat (5) @(negedge clk);
        ext_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 ibf unchanged", ibf, 0);
        check("R3 irq unchanged", irq, 0);
        check("R3 byte unchanged", loc_in_data, 8'hA5);
    endtask

    task automatic test_cs_end();
        ext_write(8'h5A, 1'b1, 1'b0, 1'b0);
        check("R11 ibf set on cs release", ibf, 1);
        check("R11 byte captured", loc_in_data, 8'h5A);
        loc_pulse_in_rd();
        loc_pulse_irq_clr();
    endtask

    task automatic test_overflow();
        ext_write(8'h11, 1'b0, 1'b0, 1'b0);
        check("R8 first write no overflow", ovf, 0);
        ext_write(8'h22, 1'b0, 1'b1, 1'b1);
        check("R8 overflow set", ovf, 1);
        check("R8 newer byte captured", loc_in_data, 8'h22);
        loc_pulse_in_rd();
        check("R8 ibf cleared by local read", ibf, 0);
        check("R8 overflow survives local read", ovf, 1);
        @(negedge clk); loc_ovf_clr = 1'b1;
        @(negedge clk); loc_ovf_clr = 1'b0;
        check("R8 overflow cleared", ovf, 0);
        loc_pulse_irq_clr();
    endtask

    task automatic test_read();
        #1;
        check("R4 oe idle", ext_data_oe, 0);
        @(negedge clk);
        loc_out_wdata = 8'hC3;
        loc_out_wr    = 1'b1;
        @(negedge clk);
        loc_out_wr = 1'b0;
        check("R5 obf set", obf, 1);
        check("R5 irq untouched by local load", irq, 0);
        ext_read(1'b1, 8'hC3, 1'b1);
        check("R6 obf cleared", obf, 0);
        check("R6 irq set", irq, 1);
        // Read strobe without chip select must not drive the bus
        @(negedge clk);
        ext_rd_n = 1'b0;
        #1;
        check("R4 oe off without cs", ext_data_oe, 0);
        @(negedge clk);
        ext_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        loc_pulse_irq_clr();
    endtask

    task automatic test_irq_race();
        @(negedge clk);
        ext_data_in = 8'h77;
        ext_cs_n    = 1'b0;
        ext_wr_n    = 1'b0;
        repeat (4) @(negedge clk);
        ext_wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        loc_irq_clr = 1'b1;       // coincides with the pending write completion
        @(negedge clk);
        loc_irq_clr = 1'b0;
        ext_cs_n    = 1'b1;
        check("R9 set wins over clear", irq, 1);
        check("R9 race write captured", loc_in_data, 8'h77);
        loc_pulse_in_rd();
        loc_pulse_irq_clr();
        check("R9 irq cleared after race", irq, 0);
    endtask

    task automatic test_mode_off();
        @(negedge clk);
        mode_en       = 1'b0;
        loc_out_wdata = 8'h99;
        loc_out_wr    = 1'b1;
        @(negedge clk);
        loc_out_wr = 1'b0;
        ext_write(8'h44, 1'b0, 1'b0, 1'b0);
        ext_read(1'b0, 8'h00, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 ibf unchanged", ibf, 0);
        check("R10 obf unchanged", obf, 1);
        check("R10 irq unchanged", irq, 0);
        check("R10 byte unchanged", loc_in_data, 8'h77);
        mode_en = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_write();
        test_local_read();
        test_cs_gate();
        test_cs_end();
        test_overflow();
        test_read();
        test_irq_race();
        test_mode_off();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule